// File: doc/BRIEF.md
# Pin Port Register Bank

This block is one general-purpose I/O port of a chip. It has 32 pins by default. Software reaches it through a plain single-cycle register interface: an address, write data, a write strobe and combinational read data. The port holds two registers with one bit per pin. The drive-value register sets the level each pin would drive. The direction register makes a pin an output when its bit is 1 and an input when its bit is 0. A third, read-only view returns the live pin levels after a two-flop synchronizer. The block feeds the per-pin drive values and tri-state enables to the pads and takes the per-pin input levels back.

Each writable register can be reached at three addresses. A write to the base address replaces the whole register. A write to base+0x4 sets the bits written as one. A write to base+0x8 clears the bits written as one. Through the two aliases, a driver can change single pins without a read-modify-write, so two agents that touch different pins never race. The drive-value register keeps its contents while a pin is an input. A driver can therefore load the level first and then turn the pin around, and the pin starts driving the intended value.

Port number `PORT_IDX` selects the slot inside each register group. The group bases are 0x0700 for drive values, 0x0900 for pin levels and 0x0B00 for direction, and each port adds `PORT_IDX`×0x10 to the group base.

Top module: `pinbank_port`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the drive-value and direction registers both become all zeros, so every pin is an input.
- R2: A write to a register's base address (drive values at 0x0700+`PORT_IDX`×0x10, direction at 0x0B00+`PORT_IDX`×0x10) replaces all of its bits with the write data at the next edge.
- R3: A write to base+0x4 ORs the write data into the register, and bits written as zero keep their value.
- R4: A write to base+0x8 clears every bit written as one, and bits written as zero keep their value.
- R5: A read at the base address, at base+0x4 or at base+0x8 of either writable register returns that register's current contents.
- R6: A read at 0x0900+`PORT_IDX`×0x10 (or at its +0x4 or +0x8 alias) returns the pin levels. A change on `pin_in` appears there after exactly two rising clock edges.
- R7: A write to the pin-level group, or to any address that is not one of the six writable addresses, leaves both registers unchanged. A read of an unmapped address returns zero.
- R8: `pin_out` always reflects the drive-value register, whatever the direction bits hold. `pin_oe` bit i is 1 exactly when pin i is an output.
- R9: Each register bit i controls or observes pin i only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | PIN_COUNT | Write data |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_rdata | output | PIN_COUNT | Read data for `bus_addr`, combinational |
| pin_in | input | PIN_COUNT | Pin levels from the pads (asynchronous) |
| pin_out | output | PIN_COUNT | Drive value per pin |
| pin_oe | output | PIN_COUNT | Output enable per pin, 1 = drive |

## Verification
A write can land on a register in the same cycle that the register's state is also read back or its pin is turned around. The critical overlap is a direction change arriving while the drive-value register already holds a pre-loaded level. The bench loads drive values with the direction bits clear, then sets direction through the set alias. It checks that `pin_out` does not move while `pin_oe` flips, which catches any design that gates the drive register by direction. A sweep also writes and reads every aligned address around the three groups against an arithmetic model, and it changes `pin_in` while reading back to judge the synchronizer delay edge by edge.

// File: rtl/pinbank_pkg.sv
// Shared types and address constants for the pin port register bank.
// Assumes byte addressing and word-aligned register slots.
package pinbank_pkg;

    // How a write acts on the selected register.
    typedef enum logic [1:0] {
        ACC_PLAIN = 2'd0,
        ACC_SET   = 2'd1,
        ACC_CLR   = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    // Which register group an address falls in.
    typedef enum logic [1:0] {
        GRP_DRIVE = 2'd0,
        GRP_LEVEL = 2'd1,
        GRP_DIR   = 2'd2,
        GRP_NONE  = 2'd3
    } grp_e;

    localparam int unsigned DRIVE_GROUP_BASE = 32'h0700;
    localparam int unsigned LEVEL_GROUP_BASE = 32'h0900;
    localparam int unsigned DIR_GROUP_BASE   = 32'h0B00;
    localparam int unsigned PORT_STRIDE      = 32'h10;
    localparam int unsigned SET_OFFSET       = 32'h4;
    localparam int unsigned CLR_OFFSET       = 32'h8;

endpackage

// File: rtl/pinbank_decode.sv
// Address decoder: maps a byte address onto a register group and an access kind.
// Assumes every group slot of this port starts at group base + PORT_IDX*stride.
module pinbank_decode
    import pinbank_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int PORT_IDX = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output grp_e              grp,
    output acc_e              acc
);
    localparam logic [ADDR_W-1:0] SLOT_DRIVE = ADDR_W'(DRIVE_GROUP_BASE + PORT_IDX * PORT_STRIDE);
    localparam logic [ADDR_W-1:0] SLOT_LEVEL = ADDR_W'(LEVEL_GROUP_BASE + PORT_IDX * PORT_STRIDE);
    localparam logic [ADDR_W-1:0] SLOT_DIR   = ADDR_W'(DIR_GROUP_BASE + PORT_IDX * PORT_STRIDE);

    logic [ADDR_W-1:0] off_drive, off_level, off_dir;

    // Classify an offset inside a slot as base, set alias or clear alias.
    function automatic acc_e kind_of(input logic [ADDR_W-1:0] off);
        if (off == ADDR_W'(0))               return ACC_PLAIN;
        else if (off == ADDR_W'(SET_OFFSET)) return ACC_SET;
        else if (off == ADDR_W'(CLR_OFFSET)) return ACC_CLR;
        else                                 return ACC_NONE;
    endfunction

    assign off_drive = addr - SLOT_DRIVE;
    assign off_level = addr - SLOT_LEVEL;
    assign off_dir   = addr - SLOT_DIR;

    // Pick the group whose slot contains the address.
    always_comb begin
        grp = GRP_NONE;
        acc = ACC_NONE;
        if (kind_of(off_drive) != ACC_NONE) begin
            grp = GRP_DRIVE;
            acc = kind_of(off_drive);
        end else if (kind_of(off_level) != ACC_NONE) begin
            grp = GRP_LEVEL;
            acc = kind_of(off_level);
        end else if (kind_of(off_dir) != ACC_NONE) begin
            grp = GRP_DIR;
            acc = kind_of(off_dir);
        end
    end
endmodule

// File: rtl/pinbank_reg.sv
// One writable per-pin register with replace, set-ones and clear-ones writes.
// Assumes at most one write per cycle; reset is synchronous and active low.
module pinbank_reg
    import pinbank_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  acc_e             wr_kind,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] q
);
    // Apply the write according to its kind; other cycles hold the value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            unique case (wr_kind)
                ACC_PLAIN: q <= wr_data;
                ACC_SET:   q <= q | wr_data;
                ACC_CLR:   q <= q & ~wr_data;
                default:   q <= q;
            endcase
        end
    end
endmodule

// File: rtl/pinbank_sync.sv
// Two-flop synchronizer, one chain per pin, for asynchronous pad inputs.
// Assumes each pin is independent; no bus-coherence between bits is given.
module pinbank_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q, stable_q;

        // Two stages resolve metastability before the level is read.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q   <= 1'b0;
                stable_q <= 1'b0;
            end else begin
                meta_q   <= async_in[b];
                stable_q <= meta_q;
            end
        end

        assign sync_out[b] = stable_q;
    end
endmodule

// File: rtl/pinbank_port.sv
// Pin port register bank: drive values, directions and synchronized pin levels
// behind a single-cycle register interface with set/clear aliases.
// Assumes one access per cycle and reads that complete combinationally.
module pinbank_port
    import pinbank_pkg::*;
#(
    parameter int PIN_COUNT = 32,
    parameter int ADDR_W    = 16,
    parameter int PORT_IDX  = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [PIN_COUNT-1:0] bus_wdata,
    input  logic                 bus_we,
    output logic [PIN_COUNT-1:0] bus_rdata,
    input  logic [PIN_COUNT-1:0] pin_in,
    output logic [PIN_COUNT-1:0] pin_out,
    output logic [PIN_COUNT-1:0] pin_oe
);
    grp_e                 sel_grp;
    acc_e                 sel_acc;
    logic [PIN_COUNT-1:0] drive_q, dir_q, level_s;

    pinbank_decode #(.ADDR_W(ADDR_W), .PORT_IDX(PORT_IDX)) u_dec (
        .addr (bus_addr),
        .grp  (sel_grp),
        .acc  (sel_acc)
    );

    pinbank_reg #(.WIDTH(PIN_COUNT)) u_drive (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we && sel_grp == GRP_DRIVE),
        .wr_kind (sel_acc),
        .wr_data (bus_wdata),
        .q       (drive_q)
    );

    pinbank_reg #(.WIDTH(PIN_COUNT)) u_dir (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_we && sel_grp == GRP_DIR),
        .wr_kind (sel_acc),
        .wr_data (bus_wdata),
        .q       (dir_q)
    );

    pinbank_sync #(.WIDTH(PIN_COUNT)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (level_s)
    );

    // Return the addressed view; unmapped addresses read as zero.
    always_comb begin
        unique case (sel_grp)
            GRP_DRIVE: bus_rdata = drive_q;
            GRP_LEVEL: bus_rdata = level_s;
            GRP_DIR:   bus_rdata = dir_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign pin_out = drive_q;
    assign pin_oe  = dir_q;
endmodule

// File: rtl/pinbank_port_chk.sv
// Port-level checker for pinbank_port, attached by bind below.
// Assumes the same address map parameters as the checked instance.
module pinbank_port_chk
    import pinbank_pkg::*;
#(
    parameter int PIN_COUNT = 32,
    parameter int ADDR_W    = 16,
    parameter int PORT_IDX  = 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [PIN_COUNT-1:0] bus_wdata,
    input logic                 bus_we,
    input logic [PIN_COUNT-1:0] bus_rdata,
    input logic [PIN_COUNT-1:0] pin_out,
    input logic [PIN_COUNT-1:0] pin_oe
);
    localparam logic [ADDR_W-1:0] A_DRV     = ADDR_W'(DRIVE_GROUP_BASE + PORT_IDX * PORT_STRIDE);
    localparam logic [ADDR_W-1:0] A_DRV_SET = ADDR_W'(DRIVE_GROUP_BASE + PORT_IDX * PORT_STRIDE + SET_OFFSET);
    localparam logic [ADDR_W-1:0] A_DIR     = ADDR_W'(DIR_GROUP_BASE + PORT_IDX * PORT_STRIDE);
    localparam logic [ADDR_W-1:0] A_DIR_CLR = ADDR_W'(DIR_GROUP_BASE + PORT_IDX * PORT_STRIDE + CLR_OFFSET);

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && pin_oe == '0));

    assert_plain_replace_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DIR) |=> pin_oe == $past(bus_wdata));

    assert_set_alias_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DRV_SET) |=> pin_out == ($past(pin_out) | $past(bus_wdata)));

    assert_clr_alias_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_DIR_CLR) |=> pin_oe == ($past(pin_oe) & ~$past(bus_wdata)));

    assert_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_DRV) |-> bus_rdata == pin_out);

    assert_idle_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind pinbank_port pinbank_port_chk #(
    .PIN_COUNT (PIN_COUNT),
    .ADDR_W    (ADDR_W),
    .PORT_IDX  (PORT_IDX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/test_pinbank_port.sv
// Self-checking bench for pinbank_port: address sweep against an arithmetic model.
module test_pinbank_port;
    localparam int CLK_PERIOD = 10;
    localparam int NPIN       = 32;
    localparam int AW         = 16;
    localparam int PORT       = 1;
    localparam int A_DRV      = 32'h0700 + PORT * 16;
    localparam int A_LVL      = 32'h0900 + PORT * 16;
    localparam int A_DIR      = 32'h0B00 + PORT * 16;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [AW-1:0]   bus_addr;
    logic [NPIN-1:0] bus_wdata;
    logic            bus_we;
    logic [NPIN-1:0] bus_rdata;
    logic [NPIN-1:0] pin_in;
    logic [NPIN-1:0] pin_out;
    logic [NPIN-1:0] pin_oe;

    int n_tests = 0;
    int n_fail  = 0;
    logic [NPIN-1:0] m_drv, m_dir;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pinbank_port #(.PIN_COUNT(NPIN), .ADDR_W(AW), .PORT_IDX(PORT)) i_pinbank_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(input string req, input logic [NPIN-1:0] act, input logic [NPIN-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // -1 when the address is outside the slot, else 0 plain, 1 set, 2 clear.
    function automatic int slot_kind(input int a, input int slot);
        int d = a - slot;
        if (d == 0) return 0;
        if (d == 4) return 1;
        if (d == 8) return 2;
        return -1;
    endfunction

    function automatic logic [NPIN-1:0] apply(input logic [NPIN-1:0] v, input int k, input logic [NPIN-1:0] d);
        case (k)
            0:       return d;
            1:       return v | d;
            2:       return v & ~d;
            default: return v;
        endcase
    endfunction

    task automatic wr(input int a, input logic [NPIN-1:0] d);
        @(negedge clk);
        bus_addr  = AW'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        m_drv  = apply(m_drv, slot_kind(a, A_DRV), d);
        m_dir  = apply(m_dir, slot_kind(a, A_DIR), d);
    endtask

    function automatic logic [NPIN-1:0] exp_read(input int a);
        if (slot_kind(a, A_DRV) >= 0) return m_drv;
        if (slot_kind(a, A_LVL) >= 0) return pin_in;
        if (slot_kind(a, A_DIR) >= 0) return m_dir;
        return '0;
    endfunction

    task automatic rd_check(input string req, input int a);
        @(negedge clk);
        bus_addr = AW'(a);
        bus_we   = 1'b0;
        #1;
        check(req, bus_rdata, exp_read(a));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_drv = '0;
        m_dir = '0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        bus_we    = 1'b0;
        pin_in    = 32'hC33C_0FF0;
        m_drv     = '0;
        m_dir     = '0;
        do_reset();

        // R1: reset state, every pin an input with zero drive.
        check("R1 pin_out", pin_out, '0);
        check("R1 pin_oe", pin_oe, '0);

        // R8 / R2: pre-load drive value with direction clear, then turn pins around.
        wr(A_DRV, 32'hA5A5_5A5A);
        check("R8 drive held as input", pin_out, 32'hA5A5_5A5A);
        check("R8 oe still clear", pin_oe, '0);
        wr(A_DIR + 4, 32'hFFFF_0000);
        check("R8 drive unchanged on turn-around", pin_out, 32'hA5A5_5A5A);
        check("R8 oe set", pin_oe, 32'hFFFF_0000);

        // R9 / R3 / R4: walk each bit through set and clear aliases.
        wr(A_DRV, '0);
        wr(A_DIR, '0);
        for (int b = 0; b < NPIN; b++) begin
            wr(A_DRV + 4, NPIN'(1) << b);
            check("R3 single bit set", pin_out, m_drv);
            wr(A_DIR + 4, NPIN'(1) << b);
            check("R9 oe bit follows pin", pin_oe, m_dir);
        end
        for (int b = 0; b < NPIN; b += 2) begin
            wr(A_DRV + 8, NPIN'(1) << b);
            check("R4 single bit clear", pin_out, m_drv);
            wr(A_DIR + 8, NPIN'(3) << b);
            check("R4 pair clear", pin_oe, m_dir);
        end

        // R2..R7: sweep every aligned address across the three groups.
        for (int a = 32'h0600; a < 32'h0D00; a += 4) begin
            logic [NPIN-1:0] d;
            d = NPIN'(a * 32'h9E37_79B1) ^ 32'h5A0F_3C69;
            wr(a, d);
            if (slot_kind(a, A_DRV) < 0 && slot_kind(a, A_DIR) < 0) begin
                check("R7 ignored write pin_out", pin_out, m_drv);
                check("R7 ignored write pin_oe", pin_oe, m_dir);
            end else begin
                check("R2/R3/R4 pin_out", pin_out, m_drv);
                check("R2/R3/R4 pin_oe", pin_oe, m_dir);
            end
            rd_check("R5/R6/R7 readback", a);
        end

        // R6: a pin change needs exactly two edges to become readable.
        for (int k = 0; k < 4; k++) begin
            logic [NPIN-1:0] prev, nxt;
            prev = pin_in;
            nxt  = NPIN'((k + 1) * 32'h1357_9BDF);
            @(negedge clk);
            bus_addr = AW'(A_LVL + 4 * (k % 3));
            bus_we   = 1'b0;
            pin_in   = nxt;
            @(negedge clk);
            check("R6 one edge old level", bus_rdata, prev);
            @(negedge clk);
            check("R6 two edges new level", bus_rdata, nxt);
        end

        // R1: reset again from a busy state.
        wr(A_DRV, 32'hFFFF_FFFF);
        wr(A_DIR, 32'h0F0F_F0F0);
        do_reset();
        check("R1 pin_out after busy", pin_out, '0);
        check("R1 pin_oe after busy", pin_oe, '0);
        rd_check("R1 readback zero", A_DIR);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule